// File: doc/BRIEF.md
# Extended I/O Select Decoder

This block connects the I/O bus of a small CPU to a programmable-logic fabric. The CPU reaches sixteen fabric-side functions through only four reserved I/O addresses. Each address names a group of four select lines. A two-bit extension field, held in a control register, names the one line in that group that an access drives. During the same bus cycle the block gives the fabric gated read and write strobes. The fabric must qualify each select line with one of these strobes.

A mode bit in the control register changes what the four reserved addresses do. When the bit is set, the addresses no longer reach the fabric. They become two interrupt mask registers and two interrupt flag registers. Fabric interrupt sources set the flag bits. The CPU clears a flag bit by writing a one to it. A single request output is high whenever any flag bit that is enabled in its mask is set. Every access completes in one bus cycle: selects, strobes and read data are combinational from the bus inputs, and register writes take effect at the next clock edge.

Top module: `io_sel_decoder`

## Requirements
- R1: After reset the control register reads 0x00, every select line and both fabric strobes are low, and the interrupt request is low.
- R2: The control register sits at I/O address 0x13. Bit 7 is the mode bit and bits 1:0 are the extension field, and both can be written. Bits 6:2 ignore writes and always read as zero.
- R3: In mode 0, a read or write of base address A, B, C or D (groups 0 to 3) drives exactly one select line, the line with index group*4 + extension, for the cycle of that access only.
- R4: The fabric read strobe equals the CPU read enable and the fabric write strobe equals the CPU write enable. Each is gated so that it is high only during a mode-0 access to one of the four base addresses.
- R5: With no access, or with an access to any address other than the four base addresses, all select lines and both fabric strobes stay low.
- R6: In mode 0, a CPU read of a base address returns the value on the fabric read-data input.
- R7: In mode 1, an access to a base address drives no select line and neither fabric strobe.
- R8: In mode 1, base addresses A and B are mask registers for interrupt sources 7:0 and 15:8. Each can be written and read back.
- R9: In mode 1, base addresses C and D read as flag registers for sources 7:0 and 15:8. A high source input sets its flag bit. Writing a one clears a flag bit. When a source is high in the same cycle that its bit is cleared, the set takes priority.
- R10: The interrupt request is high exactly when some flag bit and its matching mask bit are both set.
- R11: A CPU read of an address that is neither the control register nor a base address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 6 | CPU I/O address |
| io_rd | input | 1 | CPU I/O read enable |
| io_wr | input | 1 | CPU I/O write enable |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | CPU read data |
| fab_sel | output | 16 | One-hot select lines to the fabric |
| fab_rd | output | 1 | Gated read strobe to the fabric |
| fab_wr | output | 1 | Gated write strobe to the fabric |
| fab_rdata | input | 8 | Read data from the fabric |
| fab_irq | input | 16 | Fabric interrupt sources |
| irq_req | output | 1 | Combined masked interrupt request |

## Verification
The hardest case to reach from the ports is a flag bit that is set and cleared in the same clock cycle. The stimulus holds one interrupt source high for the whole cycle in which the CPU writes a one to that flag's bit, then reads the flag register back and expects the bit still set. Reaching the remap registers at all takes a mode change first. The bench writes the mode bit, checks that accesses to the base addresses no longer move any select line, and only then exercises the masks, the flags and the request output.

// File: rtl/io_sel_pkg.sv
package io_sel_pkg;

    localparam int GROUPS = 4;
    localparam int LINES  = 4;
    localparam int EXT_W  = $clog2(LINES);
    localparam int SEL_W  = GROUPS * LINES;

    typedef struct packed {
        logic             mode;
        logic [EXT_W-1:0] ext;
    } ctrl_t;

endpackage

// File: rtl/io_sel_addr_dec.sv
module io_sel_addr_dec
    import io_sel_pkg::*;
#(
    parameter int                        ADDR_W    = 6,
    parameter logic [ADDR_W-1:0]         CTRL_ADDR = 6'h13,
    parameter logic [GROUPS*ADDR_W-1:0]  BASE_LIST = {6'h0B, 6'h0A, 6'h09, 6'h08}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [GROUPS-1:0] grp_hit,
    output logic              base_hit,
    output logic              ctrl_hit
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_cmp
        assign grp_hit[g] = (addr == BASE_LIST[g*ADDR_W +: ADDR_W]);
    end

    assign base_hit = |grp_hit;
    assign ctrl_hit = (addr == CTRL_ADDR);

endmodule

// File: rtl/io_sel_line_gen.sv
module io_sel_line_gen
    import io_sel_pkg::*;
(
    input  logic [GROUPS-1:0] grp_hit,
    input  logic [EXT_W-1:0]  ext,
    input  logic              qualify,
    output logic [SEL_W-1:0]  sel
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar l = 0; l < LINES; l++) begin : g_line
            assign sel[g*LINES + l] = qualify & grp_hit[g] & (ext == EXT_W'(l));
        end
    end

endmodule

// File: rtl/io_sel_irq_bank.sv
module io_sel_irq_bank
    import io_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GROUPS-1:0]   grp_hit,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] src,
    output logic [DATA_W-1:0]   rd_word,
    output logic                irq_req
);

    localparam int BANKS = GROUPS / 2;

    typedef struct packed {
        logic [BANKS-1:0][DATA_W-1:0] mask;
        logic [BANKS-1:0][DATA_W-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int b = 0; b < BANKS; b++) begin
            logic [DATA_W-1:0] clr;
            if (wr_en && grp_hit[b]) begin
                bank_d.mask[b] = wdata;
            end
            clr = (wr_en && grp_hit[BANKS + b]) ? wdata : '0;
            // a source that is high wins over a clear in the same cycle
            bank_d.flag[b] = (bank_q.flag[b] & ~clr) | src[b*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (grp_hit[b])         rd_word = rd_word | bank_q.mask[b];
            if (grp_hit[BANKS + b]) rd_word = rd_word | bank_q.flag[b];
        end
    end

    assign irq_req = |(bank_q.flag & bank_q.mask);

endmodule

// File: rtl/io_sel_decoder.sv
module io_sel_decoder
    import io_sel_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h13,
    parameter logic [ADDR_W-1:0] BASE_A    = 6'h08,
    parameter logic [ADDR_W-1:0] BASE_B    = 6'h09,
    parameter logic [ADDR_W-1:0] BASE_C    = 6'h0A,
    parameter logic [ADDR_W-1:0] BASE_D    = 6'h0B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [DATA_W-1:0]   io_wdata,
    output logic [DATA_W-1:0]   io_rdata,
    output logic [SEL_W-1:0]    fab_sel,
    output logic                fab_rd,
    output logic                fab_wr,
    input  logic [DATA_W-1:0]   fab_rdata,
    input  logic [2*DATA_W-1:0] fab_irq,
    output logic                irq_req
);

    localparam logic [GROUPS*ADDR_W-1:0] BASE_LIST = {BASE_D, BASE_C, BASE_B, BASE_A};

    logic [GROUPS-1:0] grp_hit;
    logic              base_hit;
    logic              ctrl_hit;
    logic [DATA_W-1:0] bank_word;
    logic [DATA_W-1:0] ctrl_word;

    ctrl_t ctrl_d, ctrl_q;

    io_sel_addr_dec #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .BASE_LIST (BASE_LIST)
    ) i_addr_dec (
        .addr     (io_addr),
        .grp_hit  (grp_hit),
        .base_hit (base_hit),
        .ctrl_hit (ctrl_hit)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (io_wr && ctrl_hit) begin
            ctrl_d.mode = io_wdata[DATA_W-1];
            ctrl_d.ext  = io_wdata[EXT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign fab_rd = io_rd & base_hit & ~ctrl_q.mode;
    assign fab_wr = io_wr & base_hit & ~ctrl_q.mode;

    io_sel_line_gen i_line_gen (
        .grp_hit (grp_hit),
        .ext     (ctrl_q.ext),
        .qualify (fab_rd | fab_wr),
        .sel     (fab_sel)
    );

    io_sel_irq_bank #(
        .DATA_W (DATA_W)
    ) i_irq_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_hit (grp_hit),
        .wr_en   (io_wr & ctrl_q.mode),
        .wdata   (io_wdata),
        .src     (fab_irq),
        .rd_word (bank_word),
        .irq_req (irq_req)
    );

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[DATA_W-1]      = ctrl_q.mode;
        ctrl_word[EXT_W-1:0]     = ctrl_q.ext;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (ctrl_hit) begin
                io_rdata = ctrl_word;
            end else if (base_hit) begin
                io_rdata = ctrl_q.mode ? bank_word : fab_rdata;
            end
        end
    end

endmodule

// File: rtl/io_sel_decoder_chk.sv
module io_sel_decoder_chk #(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                SEL_W     = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h13
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   io_addr,
    input logic                io_rd,
    input logic                io_wr,
    input logic [DATA_W-1:0]   io_rdata,
    input logic [SEL_W-1:0]    fab_sel,
    input logic                fab_rd,
    input logic                fab_wr,
    input logic [DATA_W-1:0]   fab_rdata,
    input logic [2*DATA_W-1:0] fab_irq,
    input logic                irq_req,
    input logic                mode
);

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fab_sel));

    assert_sel_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|fab_sel) |-> (fab_rd || fab_wr));

    assert_rd_strobe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fab_rd |-> io_rd);

    assert_wr_strobe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fab_wr |-> io_wr);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == CTRL_ADDR) |-> (io_rdata[DATA_W-2:2] == '0));

    assert_fabric_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && fab_rd) |-> (io_rdata == fab_rdata));

    assert_remap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (fab_sel == '0 && !fab_rd && !fab_wr));

    assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(|fab_irq) || $past(io_wr)));

endmodule

bind io_sel_decoder io_sel_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SEL_W     (io_sel_pkg::SEL_W),
    .CTRL_ADDR (CTRL_ADDR)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_rdata  (io_rdata),
    .fab_sel   (fab_sel),
    .fab_rd    (fab_rd),
    .fab_wr    (fab_wr),
    .fab_rdata (fab_rdata),
    .fab_irq   (fab_irq),
    .irq_req   (irq_req),
    .mode      (ctrl_q.mode)
);

// File: tb/test_io_sel_decoder.sv
module test_io_sel_decoder;

    localparam int          CLK_PERIOD = 10;
    localparam logic [5:0]  CTRL       = 6'h13;
    localparam logic [5:0]  BASES [4]  = '{6'h08, 6'h09, 6'h0A, 6'h0B};
    localparam logic [5:0]  UNMAPPED   = 6'h20;

    // vector: [12:11] ext, [10:9] group, [8] 1=read 0=write, [7:0] data
    localparam logic [12:0] VEC [8] = '{
        {2'd0, 2'd0, 1'b0, 8'h11}, {2'd3, 2'd0, 1'b1, 8'hA5},
        {2'd1, 2'd1, 1'b0, 8'h22}, {2'd2, 2'd1, 1'b1, 8'h3C},
        {2'd2, 2'd2, 1'b0, 8'h44}, {2'd0, 2'd2, 1'b1, 8'hC3},
        {2'd3, 2'd3, 1'b0, 8'h66}, {2'd1, 2'd3, 1'b1, 8'h0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] fab_sel;
    logic        fab_rd;
    logic        fab_wr;
    logic [7:0]  fab_rdata = '0;
    logic [15:0] fab_irq = '0;
    logic        irq_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [15:0] s_sel;
    logic        s_rd, s_wr;
    logic [7:0]  s_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_sel_decoder i_io_sel_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .fab_sel   (fab_sel),
        .fab_rd    (fab_rd),
        .fab_wr    (fab_wr),
        .fab_rdata (fab_rdata),
        .fab_irq   (fab_irq),
        .irq_req   (irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic snap();
        s_sel   = fab_sel;
        s_rd    = fab_rd;
        s_wr    = fab_wr;
        s_rdata = io_rdata;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #(CLK_PERIOD/4);
        snap();
        @(posedge clk);
        #1;
        io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic bus_rd(input logic [5:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #(CLK_PERIOD/4);
        snap();
        @(posedge clk);
        #1;
        io_rd = 1'b0; io_addr = '0;
    endtask

    task automatic pulse_irq(input logic [15:0] v);
        @(negedge clk);
        fab_irq = v;
        @(posedge clk);
        #1;
        fab_irq = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        #(CLK_PERIOD/4);
        check("R1 sel", fab_sel, 16'h0);
        check("R1 strobes", {fab_rd, fab_wr}, 2'b00);
        check("R1 irq", irq_req, 1'b0);
        bus_rd(CTRL);
        check("R1 ctrl", s_rdata, 8'h00);

        // R3/R4/R6: vector walk in mode 0
        foreach (VEC[i]) begin
            logic [1:0] e, g;
            logic       rd;
            logic [7:0] d;
            {e, g, rd, d} = VEC[i];
            bus_wr(CTRL, {6'b0, e});
            fab_rdata = d;
            if (rd) bus_rd(BASES[g]);
            else    bus_wr(BASES[g], d);
            check("R3 sel index", s_sel, 16'(1) << (g*4 + e));
            check("R4 strobes", {s_rd, s_wr}, {rd, ~rd});
            if (rd) check("R6 fabric data", s_rdata, d);
            #(CLK_PERIOD/2);
            check("R3 sel cleared", fab_sel, 16'h0);
        end
        fab_rdata = 8'h00;

        // R2: reserved bits
        bus_wr(CTRL, 8'h7E);
        bus_rd(CTRL);
        check("R2 reserved", s_rdata, 8'h02);
        bus_wr(CTRL, 8'hFF);
        bus_rd(CTRL);
        check("R2 mode+ext", s_rdata, 8'h83);
        bus_wr(CTRL, 8'h01);

        // R5: no access, control access, unmapped access
        @(negedge clk);
        check("R5 idle", {fab_sel, fab_rd, fab_wr}, 18'h0);
        bus_wr(CTRL, 8'h01);
        check("R5 ctrl access", {s_sel, s_rd, s_wr}, 18'h0);
        fab_rdata = 8'hEE;
        bus_rd(UNMAPPED);
        check("R5 unmapped", {s_sel, s_rd, s_wr}, 18'h0);
        check("R11 unmapped read", s_rdata, 8'h00);
        bus_wr(UNMAPPED, 8'h55);
        check("R5 unmapped wr", {s_sel, s_rd, s_wr}, 18'h0);

        // R7/R8: remap mode
        bus_wr(CTRL, 8'h80);
        bus_wr(BASES[0], 8'h5A);
        check("R7 quiet write", {s_sel, s_rd, s_wr}, 18'h0);
        bus_rd(BASES[0]);
        check("R7 quiet read", {s_sel, s_rd, s_wr}, 18'h0);
        check("R8 mask A", s_rdata, 8'h5A);
        bus_wr(BASES[1], 8'h0F);
        bus_rd(BASES[1]);
        check("R8 mask B", s_rdata, 8'h0F);
        check("R10 no flags", irq_req, 1'b0);

        // R9/R10: flags
        pulse_irq(16'h0102);
        bus_rd(BASES[2]);
        check("R9 flag C", s_rdata, 8'h02);
        bus_rd(BASES[3]);
        check("R9 flag D", s_rdata, 8'h01);
        check("R10 irq set", irq_req, 1'b1);
        bus_wr(BASES[2], 8'h02);
        bus_rd(BASES[2]);
        check("R9 clear C", s_rdata, 8'h00);
        check("R10 irq via D", irq_req, 1'b1);
        bus_wr(BASES[3], 8'h01);
        #(CLK_PERIOD/4);
        check("R10 irq cleared", irq_req, 1'b0);

        // R10: masked flag does not request
        pulse_irq(16'h0004);
        bus_rd(BASES[2]);
        check("R9 masked flag", s_rdata, 8'h04);
        check("R10 masked", irq_req, 1'b0);
        bus_wr(BASES[0], 8'h04);
        #(CLK_PERIOD/4);
        check("R10 mask enables", irq_req, 1'b1);

        // R9: set wins over clear in the same cycle
        @(negedge clk);
        fab_irq = 16'h0008;
        bus_wr(BASES[2], 8'h0C);
        fab_irq = '0;
        bus_rd(BASES[2]);
        check("R9 set wins", s_rdata, 8'h08);

        // back to mode 0: selects return (R3)
        bus_wr(CTRL, 8'h02);
        bus_wr(BASES[1], 8'h00);
        check("R3 after remap", s_sel, 16'h0040);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule